// File: doc/BRIEF.md
# Debounced Pushbutton Status Output

This block turns a raw, active-low pushbutton input into a clean active-low status signal. The signal is meant for an open-drain pin. The button is first brought into the clock domain by a two-flop synchronizer. A low level is then accepted only after it has lasted a set number of 1 ms ticks without interruption. Once the status output is pulled low, it is held low for a minimum number of ticks, even if the button bounces back earlier. After that minimum it follows the button and lets go when the button is released.

The output is allowed to follow the button only while the power controller is in one of its awake states:
- first power-up (code 1)
- second power-up (code 2)
- run (code 3)

In the remaining states the pin stays released:
- hard-reset (code 0)
- first power-down (code 4)
- second power-down (code 5)
- off (code 6)

The controller also raises a one-cycle flag for the press that woke the system. That press never reaches the status output. Only a later, separate press does.

Inside, a status state machine has four states:
- `F_IDLE`: released, waiting for a qualified press.
- `F_SUPPRESS`: released, ignoring the wake press until the button is seen high.
- `F_HOLD`: driving low while the minimum-width timer runs.
- `F_FOLLOW`: driving low after the minimum width, until the button is released.

Its transitions are:
- IDLE→SUPPRESS on the wake flag.
- IDLE→HOLD on a qualified press in an awake state.
- SUPPRESS→IDLE on a released button with no wake flag.
- HOLD→FOLLOW when the minimum width has elapsed and the button is still low.
- HOLD→IDLE when the minimum width has elapsed with the button high, or when the power state leaves the awake set.
- FOLLOW→IDLE on button release or when the power state leaves the awake set.

Top module: `btnstat`

## Requirements
- R1: The status output is driven (`stat_oe`=1, `stat_n`=0) only after the synchronized button has been low for `DEB_TICKS` consecutive ticks. It becomes driven on the clock after the `DEB_TICKS`-th tick is counted.
- R2: After the minimum width, the output is released three clocks after `button_n` rises: two synchronizer stages plus one state update.
- R3: Once driven, the output stays driven for at least `MIN_TICKS` ticks, even when the button is released earlier. It is then released if the button is high.
- R4: The output may be driven only while `pwr_state` is 1, 2 or 3. For codes 0, 4, 5 and 6 it is released in the same cycle the code appears, including in the middle of a stretched pulse.
- R5: A `boot_press` pulse while released keeps the current press from driving the output until the synchronized button has been seen high. A later press of `DEB_TICKS` ticks drives the output.
- R6: Any high sample of the synchronized button restarts the low-duration count from zero.
- R7: While reset is asserted and after it is released, the output is released (`stat_oe`=0, `stat_n`=1).
- R8: The low-duration count saturates at `DEB_TICKS`, so a press held far longer keeps the output driven without interruption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| button_n | input | 1 | Raw pushbutton, low when pressed |
| pwr_state | input | 3 | Power controller state code (0 hard-reset, 1/2 power-up, 3 run, 4/5 power-down, 6 off) |
| boot_press | input | 1 | Pulse marking the press that woke the system |
| stat_n | output | 1 | Pin level: 0 while pulled low, 1 while released |
| stat_oe | output | 1 | Open-drain enable: 1 pulls the pin low |

## Verification
The results fall due at different times.
- Release on button rise (R2) is due exactly three clocks after the input changes. The bench checks the output still driven at the second following falling edge and released at the third.
- Gating (R4) is combinational, so the bench checks it a moment after the state code changes, within the same cycle.
- Debounce qualification and the minimum width (R1, R3) depend on where the free-running tick falls. The bench therefore brackets them: the output must be quiet at 48 tick periods after the press, must rise no later than 50 tick periods plus four clocks, and must stay driven 45 tick periods after rising.
- All outputs are sampled on falling clock edges, away from the edge that updates them.

// File: rtl/btnstat_pkg.sv
package btnstat_pkg;

    typedef enum logic [2:0] {
        PS_HARDRST = 3'd0,
        PS_WAKE_A  = 3'd1,
        PS_WAKE_B  = 3'd2,
        PS_RUN     = 3'd3,
        PS_SHUT_A  = 3'd4,
        PS_SHUT_B  = 3'd5,
        PS_OFF     = 3'd6
    } pwr_state_e;

    typedef enum logic [1:0] {
        F_IDLE     = 2'd0,
        F_SUPPRESS = 2'd1,
        F_HOLD     = 2'd2,
        F_FOLLOW   = 2'd3
    } stat_fsm_e;

    // Awake states are the only ones in which the status pin may be driven.
    function automatic logic is_awake(input logic [2:0] code);
        logic r;
        case (code)
            PS_WAKE_A, PS_WAKE_B, PS_RUN: r = 1'b1;
            default:                      r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/btnstat_sync.sv
module btnstat_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/btnstat_lowtimer.sv
module btnstat_lowtimer #(
    parameter int DEB_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_high,
    output logic low_ok
);

    localparam int             CW      = $clog2(DEB_TICKS + 1);
    localparam logic [CW-1:0]  DEB_TOP = CW'(DEB_TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (btn_high) begin
            cnt <= '0;
        end else if (tick && (cnt != DEB_TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign low_ok = (cnt == DEB_TOP);

    assert_cnt_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DEB_TOP)
        else $error("low-duration count beyond threshold");

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> !$past(btn_high))
        else $error("count nonzero after a high sample");

endmodule

// File: rtl/btnstat_fsm.sv
module btnstat_fsm
    import btnstat_pkg::*;
#(
    parameter int MIN_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_high,
    input  logic low_ok,
    input  logic awake,
    input  logic boot_press,
    output logic drive_raw
);

    localparam int            TW      = $clog2(MIN_TICKS + 1);
    localparam logic [TW-1:0] MIN_TOP = TW'(MIN_TICKS);

    stat_fsm_e     st, nxt;
    logic [TW-1:0] tmr;
    logic          min_done;

    assign min_done = (tmr == MIN_TOP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= F_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // minimum-width timer, runs only while holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr <= '0;
        end else if (st != F_HOLD) begin
            tmr <= '0;
        end else if (tick && !min_done) begin
            tmr <= tmr + 1'b1;
        end
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            F_IDLE: begin
                if (boot_press)            nxt = F_SUPPRESS;
                else if (awake && low_ok)  nxt = F_HOLD;
            end
            F_SUPPRESS: begin
                if (btn_high && !boot_press) nxt = F_IDLE;
            end
            F_HOLD: begin
                if (!awake)                nxt = F_IDLE;
                else if (min_done)         nxt = btn_high ? F_IDLE : F_FOLLOW;
            end
            F_FOLLOW: begin
                if (!awake || btn_high)    nxt = F_IDLE;
            end
            default:                       nxt = F_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        drive_raw = (st == F_HOLD) || (st == F_FOLLOW);
    end

    assert_qualified_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_raw) |-> ($past(low_ok) && $past(awake)))
        else $error("drive began without a qualified press");

    assert_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == F_HOLD && st == F_IDLE && $past(awake)) |-> $past(min_done))
        else $error("pulse ended before minimum width");

    assert_follow_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == F_FOLLOW && btn_high) |=> !drive_raw)
        else $error("drive kept after release");

    assert_suppress_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == F_SUPPRESS && st != F_SUPPRESS) |-> ($past(btn_high) && st == F_IDLE))
        else $error("suppression left without release");

endmodule

// File: rtl/btnstat.sv
module btnstat
    import btnstat_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_TICKS   = 50,
    parameter int MIN_TICKS   = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       button_n,
    input  logic [2:0] pwr_state,
    input  logic       boot_press,
    output logic       stat_n,
    output logic       stat_oe
);

    logic btn_high;
    logic low_ok;
    logic awake;
    logic drive_raw;

    assign awake = is_awake(pwr_state);

    btnstat_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (button_n),
        .q_sync  (btn_high)
    );

    btnstat_lowtimer #(
        .DEB_TICKS (DEB_TICKS)
    ) u_lowtimer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_ms),
        .btn_high (btn_high),
        .low_ok   (low_ok)
    );

    btnstat_fsm #(
        .MIN_TICKS (MIN_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_ms),
        .btn_high   (btn_high),
        .low_ok     (low_ok),
        .awake      (awake),
        .boot_press (boot_press),
        .drive_raw  (drive_raw)
    );

    // Gating is combinational so a sleeping state releases the pin at once.
    assign stat_oe = drive_raw && awake;
    assign stat_n  = !stat_oe;

    assert_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !is_awake(pwr_state) |-> !stat_oe)
        else $error("pin driven in a sleeping state");

    assert_reset_R7: assert property (@(posedge clk)
        !rst_n |-> (!stat_oe && stat_n))
        else $error("pin driven during reset");

endmodule

// File: tb/btnstat_tb.sv
`timescale 1ns/1ps
module btnstat_tb;
    import btnstat_pkg::*;

    localparam int P   = 4;   // clocks per tick
    localparam int DEB = 50;
    localparam int MIN = 50;
    localparam int NV  = 9;

    localparam logic [2:0] V_ST [NV] = '{3'd3, 3'd3, 3'd1, 3'd2, 3'd0, 3'd6, 3'd4, 3'd5, 3'd3};
    localparam int         V_LEN[NV] = '{20, 60, 60, 60, 60, 60, 60, 60, 45};
    localparam bit         V_EXP[NV] = '{0, 1, 1, 1, 0, 0, 0, 0, 0};

    logic       clk = 0;
    logic       rst_n = 0;
    logic       tick_ms = 0;
    logic       button_n = 1;
    logic [2:0] pwr_state = 3'd0;
    logic       boot_press = 0;
    logic       stat_n;
    logic       stat_oe;

    int  errors = 0;
    int  checks = 0;
    bit  seen = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    btnstat #(.SYNC_STAGES(2), .DEB_TICKS(DEB), .MIN_TICKS(MIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .button_n(button_n),
        .pwr_state(pwr_state), .boot_press(boot_press),
        .stat_n(stat_n), .stat_oe(stat_oe)
    );

    initial begin
        forever begin
            repeat (P - 1) @(negedge clk);
            tick_ms = 1;
            @(negedge clk);
            tick_ms = 0;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (stat_oe) seen = 1;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        while (!stat_oe && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        // R7 reset
        wait_clk(3);
        check(stat_oe == 0 && stat_n == 1, "R7 in reset", stat_oe, 0);
        rst_n = 1;
        wait_clk(3);
        check(stat_oe == 0 && stat_n == 1, "R7 after reset", stat_oe, 0);

        // table of press patterns (R1, R4)
        for (int i = 0; i < NV; i++) begin
            pwr_state = V_ST[i];
            wait_clk(2);
            seen = 0;
            button_n = 0;
            wait_clk(V_LEN[i] * P);
            button_n = 1;
            wait_clk((MIN + 4) * P);
            check(seen == V_EXP[i], V_EXP[i] ? "R1 vector" : "R4/R1 vector", seen, V_EXP[i]);
            check(stat_oe == 0, "R2 vector end", stat_oe, 0);
        end

        // R1 qualification window, R8 long hold, R2 release timing
        pwr_state = PS_RUN;
        wait_clk(2);
        button_n = 0;
        wait_clk(48 * P);
        check(stat_oe == 0, "R1 early", stat_oe, 0);
        wait_rise(n);
        check(n <= 2 * P + 4, "R1 due", 48 * P + n, 50 * P + 4);
        wait_clk(150 * P);
        check(stat_oe == 1, "R8 long hold", stat_oe, 1);
        button_n = 1;
        wait_clk(2);
        check(stat_oe == 1, "R2 two clocks", stat_oe, 1);
        wait_clk(1);
        check(stat_oe == 0 && stat_n == 1, "R2 three clocks", stat_oe, 0);
        wait_clk(10);

        // R3 stretch of a short pulse
        button_n = 0;
        wait_rise(n);
        button_n = 1;
        wait_clk(45 * P);
        check(stat_oe == 1, "R3 stretched", stat_oe, 1);
        n = 0;
        while (stat_oe && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n <= 7 * P + 4, "R3 ends", 45 * P + n, 52 * P + 4);
        wait_clk(10);

        // R6 restart on a high sample
        button_n = 0;
        wait_clk(40 * P);
        button_n = 1;
        wait_clk(3);
        button_n = 0;
        wait_clk(45 * P);
        check(stat_oe == 0, "R6 restarted", stat_oe, 0);
        wait_clk(6 * P);
        check(stat_oe == 1, "R6 counts again", stat_oe, 1);
        button_n = 1;
        wait_clk((MIN + 4) * P);

        // R4 mid-stretch release on state change
        button_n = 0;
        wait_rise(n);
        wait_clk(5);
        pwr_state = PS_SHUT_A;
        #1;
        check(stat_oe == 0 && stat_n == 1, "R4 cut", stat_oe, 0);
        button_n = 1;
        wait_clk(10);
        pwr_state = PS_RUN;
        wait_clk(5);
        check(stat_oe == 0, "R4 no resume", stat_oe, 0);

        // R5 wake press suppressed
        pwr_state = PS_HARDRST;
        wait_clk(2);
        button_n = 0;
        wait_clk(10 * P);
        pwr_state = PS_WAKE_A;
        boot_press = 1;
        wait_clk(1);
        boot_press = 0;
        seen = 0;
        wait_clk(70 * P);
        check(seen == 0, "R5 wake press", seen, 0);
        button_n = 1;
        wait_clk(5);
        seen = 0;
        button_n = 0;
        wait_clk(55 * P);
        check(stat_oe == 1, "R5 later press", stat_oe, 1);
        button_n = 1;
        wait_clk((MIN + 4) * P);
        check(stat_oe == 0, "R2 final", stat_oe, 0);

        finish_run();
    end

endmodule